// File: doc/BRIEF.md
# Skid-Buffered Decode Stage Controller

This block is the control half of a decode pipeline stage for one hardware thread. Each cycle the fetch side offers up to `FETCH_W` instruction tokens, ordered oldest first. Each token carries a sequence tag, a "killed" flag and a source-operand count. The stage forwards up to `DECODE_W` live tokens per cycle to the rename side. Tokens that cannot move on are kept in a circular skid FIFO. The stage tells fetch to hold or resume with single-cycle pulses.

Three downstream stages can stall the controller independently: rename, execute and commit. The commit side can also squash the thread and can report that a squash is still in progress. While the skid FIFO drains after a stall, the stage raises an activity flag so that a clock-gating controller keeps it awake. Every output is registered and reflects the inputs of the previous clock cycle.

Top module: `decode_skid_ctrl`

## Requirements
- R1: The skid FIFO holds `UP_LAT*FETCH_W+DECODE_W` tokens and never loses or reorders one. A fill reaching `UP_LAT*FETCH_W` tokens is later drained in full.
- R2: Each stall source (rename, execute, commit) has its own flag. The flag is set by that source's block pulse and cleared by its release pulse. The stage stays held while any flag is set. A release pulse for a flag that is clear is an error.
- R3: Events are handled in this priority: squash, then squash-busy, then stall, then leaving Blocked, then leaving Squashing. Squash-busy alone keeps the stage in Squashing and produces no output.
- R4: On a stall, every token offered that cycle enters the skid FIFO and nothing is forwarded. If the stage was not already Blocked, it enters Blocked and `up_block` pulses once.
- R5: From Blocked with no stall, the stage enters Unblocking in that same cycle. It forwards from the skid FIFO oldest first and appends newly offered tokens behind them. `stage_active` is 1 exactly while the state is Unblocking.
- R6: Unblocking ends only in a cycle that empties the skid FIFO and receives no new token. In that cycle `up_release` pulses and the state becomes Running. Leaving Blocked with an empty FIFO releases at once, unless leftover tokens force a re-block. In that case no pulse is sent.
- R7: From Squashing, with no squash, no squash-busy and no stall, the stage leaves Squashing and decodes that cycle's tokens.
- R8: At most `DECODE_W` tokens are forwarded per cycle. A token with its killed flag set is dropped and uses no output slot. If offered tokens remain once the slots are full, those tokens enter the skid FIFO, the state becomes Blocked and `up_block` pulses.
- R9: A squash empties the skid FIFO, drops that cycle's tokens, forwards nothing and enters Squashing. If the state was Blocked or Unblocking, `up_release` pulses.
- R10: A forwarded token's issue-ready bit is 1 exactly when its source-operand count is zero.
- R11: After reset the state is Idle (code 0), no token is forwarded and both pulses are low. The state codes are: Idle 0, Running 1, Blocked 2, Unblocking 3, Squashing 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_count | input | $clog2(FETCH_W+1) | Number of valid tokens offered, slot 0 oldest |
| in_seq | input | FETCH_W*SEQ_W | Sequence tag of each slot |
| in_kill | input | FETCH_W | Killed flag of each slot |
| in_srcs | input | FETCH_W*SRC_W | Source-operand count of each slot |
| rn_block | input | 1 | Rename stall pulse |
| rn_release | input | 1 | Rename release pulse |
| ex_block | input | 1 | Execute stall pulse |
| ex_release | input | 1 | Execute release pulse |
| cm_block | input | 1 | Commit stall pulse |
| cm_release | input | 1 | Commit release pulse |
| cm_squash | input | 1 | Squash request from commit |
| cm_squash_busy | input | 1 | Commit still squashing |
| out_count | output | $clog2(DECODE_W+1) | Number of tokens forwarded, slot 0 oldest |
| out_seq | output | DECODE_W*SEQ_W | Sequence tag of each forwarded slot |
| out_issue_ready | output | DECODE_W | Issue-ready bit of each forwarded slot |
| up_block | output | 1 | One-cycle pulse telling fetch to hold |
| up_release | output | 1 | One-cycle pulse telling fetch to resume |
| stage_active | output | 1 | High while unblocking |
| stage_state | output | 3 | Current state code |

## Verification
Two pairs of functions often fall in the same cycle. In one pair, the skid FIFO is popped during Unblocking while in-flight fetch tokens are appended behind it. In the other, a squash or new stall arrives in the same cycle as a drain or re-block. The bench provokes both with random stall and squash pulses and with a fetch model that keeps sending for `UP_LAT-1` cycles after it sees `up_block`. It also runs directed cases: a full fill, a drain, and a squash while Blocked. Every cycle, each output is compared against a queue-based model of the requirements. The comparison covers forwarded tags, issue-ready bits, the pulses and the state.

// File: rtl/dsc_pkg.sv
// Shared definitions for the skid-buffered decode stage controller.
// Assumes one thread; state codes are visible on the stage_state port.
package dsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RUN        = 3'd1,
        ST_BLOCKED    = 3'd2,
        ST_UNBLOCKING = 3'd3,
        ST_SQUASHING  = 3'd4
    } stage_state_e;

    localparam int NUM_STALL_SRC = 3;

    // Skid capacity: tokens in flight during the upstream latency plus one decode group.
    function automatic int skid_depth(input int lat, input int fetch_w, input int decode_w);
        return lat * fetch_w + decode_w;
    endfunction

endpackage

// File: rtl/dsc_stall_flags.sv
// Keeps one stall flag per downstream source.
// A block pulse sets a flag and a release pulse clears it; a release pulse wins
// when both arrive together. stalled_o looks at the flag values after this
// cycle's pulses, so a stall acts in the cycle its pulse arrives.
// Assumes a release pulse only arrives for a flag that is set or being set.
module dsc_stall_flags #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] blk_i,
    input  logic [NSRC-1:0] rel_i,
    output logic [NSRC-1:0] flags_q,
    output logic            stalled_o
);

    logic [NSRC-1:0] flags_next;

    // Apply this cycle's pulses to the stored flags.
    always_comb begin
        flags_next = (flags_q | blk_i) & ~rel_i;
        stalled_o  = |flags_next;
    end

    // Store the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_next;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        // R2: a release pulse must target a flag that is set (or set this cycle)
        a_r2_release_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            rel_i[g] |-> (flags_q[g] || blk_i[g]));
        // R2: a lone block pulse leaves its flag set
        a_r2_block_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (blk_i[g] && !rel_i[g]) |=> flags_q[g]);
    end

endmodule

// File: rtl/dsc_skid_fifo.sv
// Circular skid FIFO with a registered head, tail and count.
// Up to PUSH_MAX tokens are written and up to DEPTH tokens removed in the same
// cycle. clear_i empties the FIFO and overrides both.
// view_o shows every slot in age order (entry 0 is the oldest); entries at or
// beyond count_o are stale.
// Assumes PUSH_MAX <= DEPTH and that the caller never overfills it.
module dsc_skid_fifo #(
    parameter int DEPTH    = 10,
    parameter int TOK_W    = 11,
    parameter int PUSH_MAX = 4,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int PCW     = $clog2(PUSH_MAX + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_i,
    input  logic [PCW-1:0]            push_n_i,
    input  logic [PUSH_MAX*TOK_W-1:0] push_data_i,
    input  logic [CW-1:0]             pop_n_i,
    output logic [DEPTH*TOK_W-1:0]    view_o,
    output logic [CW-1:0]             count_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int XW = PW + 2;

    logic [TOK_W-1:0] mem [DEPTH];
    logic [PW-1:0]    head_q, tail_q;
    logic [CW-1:0]    count_q;

    // Fold a sum of pointer plus offset (< 2*DEPTH) back into range.
    function automatic logic [PW-1:0] wrap(input logic [XW-1:0] x);
        if (x >= XW'(DEPTH)) return PW'(x - XW'(DEPTH));
        else                 return PW'(x);
    endfunction

    // Write the pushed tokens behind the tail.
    always_ff @(posedge clk) begin
        for (int k = 0; k < PUSH_MAX; k++) begin
            if (k < int'(push_n_i) && !clear_i)
                mem[wrap(XW'(tail_q) + XW'(k))] <= push_data_i[k*TOK_W +: TOK_W];
        end
    end

    // Advance the pointers and the count; a clear takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= wrap(XW'(head_q) + XW'(pop_n_i));
            tail_q  <= wrap(XW'(tail_q) + XW'(push_n_i));
            count_q <= CW'(count_q + CW'(push_n_i) - pop_n_i);
        end
    end

    // Present the contents in age order.
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            view_o[i*TOK_W +: TOK_W] = mem[wrap(XW'(head_q) + XW'(i))];
    end

    assign count_o = count_q;

    // R1: pushes never exceed the capacity
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (int'(count_q) + int'(push_n_i) - int'(pop_n_i) <= DEPTH));
    // R1: never remove more than is stored
    a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (pop_n_i <= count_q));

endmodule

// File: rtl/dsc_token_picker.sv
// Walks up to N tokens in age order and fills at most OUT_MAX output slots.
// Killed tokens are consumed without taking a slot. The walk stops when the
// slots are full or the available tokens run out; used_o counts the tokens consumed.
// Purely combinational.
module dsc_token_picker #(
    parameter int N        = 4,
    parameter int OUT_MAX  = 2,
    parameter int TOK_W    = 11,
    parameter int KILL_BIT = 2,
    localparam int NCW     = $clog2(N + 1),
    localparam int OCW     = $clog2(OUT_MAX + 1)
) (
    input  logic [N*TOK_W-1:0]       toks_i,
    input  logic [NCW-1:0]           avail_i,
    output logic [NCW-1:0]           used_o,
    output logic [OCW-1:0]           emit_n_o,
    output logic [OUT_MAX*TOK_W-1:0] emit_o
);

    // Select live tokens in order until slots or tokens run out.
    always_comb begin
        int slots;
        int used;
        logic [TOK_W-1:0] tok;
        slots  = 0;
        used   = 0;
        emit_o = '0;
        for (int i = 0; i < N; i++) begin
            tok = toks_i[i*TOK_W +: TOK_W];
            if (i < int'(avail_i) && slots < OUT_MAX) begin
                used = used + 1;
                if (!tok[KILL_BIT]) begin
                    emit_o[slots*TOK_W +: TOK_W] = tok;
                    slots = slots + 1;
                end
            end
        end
        used_o   = NCW'(used);
        emit_n_o = OCW'(slots);
    end

endmodule

// File: rtl/decode_skid_ctrl.sv
// Skid-buffered decode stage controller for one thread.
// Handles the events of each cycle in priority order: squash, squash-busy,
// stall, leaving Blocked, leaving Squashing. It forwards up to DECODE_W live
// tokens, parks unprocessed ones in the skid FIFO, and sends single-cycle hold
// and resume pulses to fetch. All outputs are registered.
// Token layout: {seq, kill, srcs}, with srcs in the low bits.
// Assumes fetch stops offering tokens UP_LAT-1 cycles after it sees up_block.
module decode_skid_ctrl #(
    parameter int FETCH_W  = 4,
    parameter int DECODE_W = 2,
    parameter int UP_LAT   = 2,
    parameter int SEQ_W    = 8,
    parameter int SRC_W    = 2,
    localparam int IN_CW   = $clog2(FETCH_W + 1),
    localparam int OUT_CW  = $clog2(DECODE_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IN_CW-1:0]          in_count,
    input  logic [FETCH_W*SEQ_W-1:0]  in_seq,
    input  logic [FETCH_W-1:0]        in_kill,
    input  logic [FETCH_W*SRC_W-1:0]  in_srcs,
    input  logic                      rn_block,
    input  logic                      rn_release,
    input  logic                      ex_block,
    input  logic                      ex_release,
    input  logic                      cm_block,
    input  logic                      cm_release,
    input  logic                      cm_squash,
    input  logic                      cm_squash_busy,
    output logic [OUT_CW-1:0]         out_count,
    output logic [DECODE_W*SEQ_W-1:0] out_seq,
    output logic [DECODE_W-1:0]       out_issue_ready,
    output logic                      up_block,
    output logic                      up_release,
    output logic                      stage_active,
    output logic [2:0]                stage_state
);
    import dsc_pkg::*;

    localparam int DEPTH    = skid_depth(UP_LAT, FETCH_W, DECODE_W);
    localparam int TOK_W    = SEQ_W + 1 + SRC_W;
    localparam int KILL_BIT = SRC_W;
    localparam int SK_CW    = $clog2(DEPTH + 1);

    stage_state_e state_q, next_state, work_state;

    logic [NUM_STALL_SRC-1:0] stall_flags;
    logic                     stalled;

    logic [FETCH_W*TOK_W-1:0]  in_toks;
    logic [FETCH_W*TOK_W-1:0]  push_data;
    logic [IN_CW-1:0]          push_n, push_off;
    logic [SK_CW-1:0]          pop_n;
    logic                      clr;
    logic [DEPTH*TOK_W-1:0]    skid_view;
    logic [SK_CW-1:0]          skid_cnt;

    logic [IN_CW-1:0]          in_used;
    logic [OUT_CW-1:0]         in_emit_n;
    logic [DECODE_W*TOK_W-1:0] in_emit;
    logic [SK_CW-1:0]          skid_used;
    logic [OUT_CW-1:0]         skid_emit_n;
    logic [DECODE_W*TOK_W-1:0] skid_emit;

    logic                      emit_en, use_skid, left_blk, blk_p, rel_p;
    logic [OUT_CW-1:0]         sel_n;
    logic [DECODE_W*TOK_W-1:0] sel_toks;

    // Assemble the incoming slots into tokens.
    always_comb begin
        for (int k = 0; k < FETCH_W; k++)
            in_toks[k*TOK_W +: TOK_W] = {in_seq[k*SEQ_W +: SEQ_W], in_kill[k],
                                         in_srcs[k*SRC_W +: SRC_W]};
    end

    dsc_stall_flags #(.NSRC(NUM_STALL_SRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_i     ({cm_block, ex_block, rn_block}),
        .rel_i     ({cm_release, ex_release, rn_release}),
        .flags_q   (stall_flags),
        .stalled_o (stalled)
    );

    dsc_token_picker #(.N(FETCH_W), .OUT_MAX(DECODE_W), .TOK_W(TOK_W),
                       .KILL_BIT(KILL_BIT)) u_pick_in (
        .toks_i   (in_toks),
        .avail_i  (in_count),
        .used_o   (in_used),
        .emit_n_o (in_emit_n),
        .emit_o   (in_emit)
    );

    dsc_token_picker #(.N(DEPTH), .OUT_MAX(DECODE_W), .TOK_W(TOK_W),
                       .KILL_BIT(KILL_BIT)) u_pick_skid (
        .toks_i   (skid_view),
        .avail_i  (skid_cnt),
        .used_o   (skid_used),
        .emit_n_o (skid_emit_n),
        .emit_o   (skid_emit)
    );

    dsc_skid_fifo #(.DEPTH(DEPTH), .TOK_W(TOK_W), .PUSH_MAX(FETCH_W)) u_skid (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clr),
        .push_n_i    (push_n),
        .push_data_i (push_data),
        .pop_n_i     (pop_n),
        .view_o      (skid_view),
        .count_o     (skid_cnt)
    );

    // Shift the unconsumed input tokens down to slot 0 for the skid push.
    always_comb begin
        for (int k = 0; k < FETCH_W; k++) begin
            if (k + int'(push_off) < FETCH_W)
                push_data[k*TOK_W +: TOK_W] = in_toks[(k + int'(push_off))*TOK_W +: TOK_W];
            else
                push_data[k*TOK_W +: TOK_W] = '0;
        end
    end

    // Resolve this cycle's events in priority order.
    always_comb begin
        next_state = state_q;
        work_state = state_q;
        push_n     = '0;
        push_off   = '0;
        pop_n      = '0;
        clr        = 1'b0;
        blk_p      = 1'b0;
        rel_p      = 1'b0;
        emit_en    = 1'b0;
        use_skid   = 1'b0;
        left_blk   = 1'b0;
        if (cm_squash) begin
            clr        = 1'b1;
            next_state = ST_SQUASHING;
            rel_p      = (state_q == ST_BLOCKED) || (state_q == ST_UNBLOCKING);
        end else if (cm_squash_busy) begin
            next_state = ST_SQUASHING;
        end else if (stalled) begin
            push_n = in_count;
            if (state_q != ST_BLOCKED) begin
                next_state = ST_BLOCKED;
                blk_p      = 1'b1;
            end
        end else begin
            if (state_q == ST_BLOCKED) begin
                if (skid_cnt == '0) begin
                    work_state = ST_RUN;
                    left_blk   = 1'b1;
                end else begin
                    work_state = ST_UNBLOCKING;
                end
            end else if (state_q == ST_SQUASHING) begin
                work_state = ST_RUN;
            end
            emit_en = 1'b1;
            if (work_state == ST_UNBLOCKING) begin
                use_skid = 1'b1;
                pop_n    = skid_used;
                push_n   = in_count;
                if (skid_used == skid_cnt && in_count == '0) begin
                    rel_p      = 1'b1;
                    next_state = ST_RUN;
                end else begin
                    next_state = ST_UNBLOCKING;
                end
            end else if (in_used != in_count) begin
                push_off   = in_used;
                push_n     = in_count - in_used;
                next_state = ST_BLOCKED;
                blk_p      = !left_blk;
            end else begin
                next_state = work_state;
                rel_p      = left_blk;
            end
        end
    end

    // Pick the token source for the output register.
    always_comb begin
        sel_n    = use_skid ? skid_emit_n : in_emit_n;
        sel_toks = use_skid ? skid_emit : in_emit;
    end

    // Register the state, forwarded tokens and fetch pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q         <= ST_IDLE;
            out_count       <= '0;
            out_seq         <= '0;
            out_issue_ready <= '0;
            up_block        <= 1'b0;
            up_release      <= 1'b0;
        end else begin
            state_q    <= next_state;
            out_count  <= emit_en ? sel_n : '0;
            up_block   <= blk_p;
            up_release <= rel_p;
            for (int s = 0; s < DECODE_W; s++) begin
                out_seq[s*SEQ_W +: SEQ_W] <= sel_toks[s*TOK_W + SRC_W + 1 +: SEQ_W];
                out_issue_ready[s]        <= (sel_toks[s*TOK_W +: SRC_W] == '0);
            end
        end
    end

    assign stage_active = (state_q == ST_UNBLOCKING);
    assign stage_state  = state_q;

    // R9: a squash leaves an empty FIFO, no output and the Squashing state
    a_r9_squash_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cm_squash |=> (skid_cnt == '0 && state_q == ST_SQUASHING && out_count == '0));
    // R3: squash-busy alone holds Squashing with no output
    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cm_squash && cm_squash_busy) |=> (state_q == ST_SQUASHING && out_count == '0));
    // R4: a stall without a squash event ends in Blocked with no output
    a_r4_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && !cm_squash && !cm_squash_busy) |=> (state_q == ST_BLOCKED && out_count == '0));
    // R4: hold and resume pulses never coincide
    a_r4_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_block && up_release));
    // R6: a resume pulse not caused by a squash means an empty FIFO and Running
    a_r6_release_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (up_release && !$past(cm_squash)) |-> (skid_cnt == '0 && state_q == ST_RUN));
    // R7: a quiet cycle moves the stage out of Squashing
    a_r7_squash_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SQUASHING && !cm_squash && !cm_squash_busy && !stalled)
        |=> (state_q != ST_SQUASHING));
    // R8: never more than DECODE_W tokens forwarded
    a_r8_width_limit: assert property (@(posedge clk) disable iff (!rst_n)
        int'(out_count) <= DECODE_W);

endmodule

// File: tb/decode_skid_ctrl_test.sv
// Self-checking bench: directed cases, then seeded random traffic. Each cycle
// is compared against a queue-based model of the requirements.
module decode_skid_ctrl_test;

    localparam int FETCH_W  = 4;
    localparam int DECODE_W = 2;
    localparam int UP_LAT   = 2;
    localparam int SEQ_W    = 8;
    localparam int SRC_W    = 2;
    localparam int IN_CW    = $clog2(FETCH_W + 1);
    localparam int OUT_CW   = $clog2(DECODE_W + 1);
    localparam int TOK_W    = SEQ_W + 1 + SRC_W;

    typedef logic [TOK_W-1:0] tok_t;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [IN_CW-1:0]          in_count = '0;
    logic [FETCH_W*SEQ_W-1:0]  in_seq = '0;
    logic [FETCH_W-1:0]        in_kill = '0;
    logic [FETCH_W*SRC_W-1:0]  in_srcs = '0;
    logic rn_block = 1'b0, rn_release = 1'b0, ex_block = 1'b0, ex_release = 1'b0;
    logic cm_block = 1'b0, cm_release = 1'b0, cm_squash = 1'b0, cm_squash_busy = 1'b0;
    logic [OUT_CW-1:0]         out_count;
    logic [DECODE_W*SEQ_W-1:0] out_seq;
    logic [DECODE_W-1:0]       out_issue_ready;
    logic                      up_block, up_release, stage_active;
    logic [2:0]                stage_state;

    decode_skid_ctrl #(.FETCH_W(FETCH_W), .DECODE_W(DECODE_W), .UP_LAT(UP_LAT),
                       .SEQ_W(SEQ_W), .SRC_W(SRC_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_count(in_count), .in_seq(in_seq),
        .in_kill(in_kill), .in_srcs(in_srcs),
        .rn_block(rn_block), .rn_release(rn_release),
        .ex_block(ex_block), .ex_release(ex_release),
        .cm_block(cm_block), .cm_release(cm_release),
        .cm_squash(cm_squash), .cm_squash_busy(cm_squash_busy),
        .out_count(out_count), .out_seq(out_seq), .out_issue_ready(out_issue_ready),
        .up_block(up_block), .up_release(up_release),
        .stage_active(stage_active), .stage_state(stage_state)
    );

    always #10 clk = ~clk;   // 50 MHz

    int   n_checks = 0;
    int   n_errs   = 0;
    bit   done     = 1'b0;

    // Model state
    int   m_state = 0;
    bit [2:0] m_flags = '0;
    tok_t m_skid[$];
    tok_t e_out[$];
    bit   e_blk, e_rel;
    string e_tag;

    // Fetch-side model
    bit   held = 1'b0;
    int   inflight = 0;
    int   seq_ctr = 0;
    int   sum_out = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Forward up to DECODE_W live tokens from q (R8): killed ones use no slot.
    task automatic take(ref tok_t q[$]);
        int slots = 0;
        while (q.size() > 0 && slots < DECODE_W) begin
            tok_t t = q.pop_front();
            if (!t[SRC_W]) begin
                e_out.push_back(t);
                slots++;
            end
        end
    endtask

    // Apply one cycle of the requirements to the model.
    task automatic model_step(input tok_t cur[$], input bit [2:0] blk, input bit [2:0] rel,
                              input bit sq, input bit busy);
        bit [2:0] f;
        int  ws;
        bit  from_blk = 1'b0;
        tok_t rest[$];
        e_out.delete();
        e_blk = 1'b0;
        e_rel = 1'b0;
        f = (m_flags | blk) & ~rel;
        m_flags = f;
        if (sq) begin                                  // R9
            e_tag = "R9";
            e_rel = (m_state == 2 || m_state == 3);
            m_skid.delete();
            m_state = 4;
        end else if (busy) begin                       // R3
            e_tag = "R3";
            m_state = 4;
        end else if (f != 0) begin                     // R4 / R2
            e_tag = (m_state == 2) ? "R2" : "R4";
            foreach (cur[i]) m_skid.push_back(cur[i]);
            if (m_state != 2) begin
                m_state = 2;
                e_blk = 1'b1;
            end
        end else begin
            ws = m_state;
            e_tag = "R8";
            if (m_state == 2) begin
                e_tag = "R5";
                if (m_skid.size() == 0) begin ws = 1; from_blk = 1'b1; end
                else ws = 3;
            end else if (m_state == 4) begin
                e_tag = "R7";
                ws = 1;
            end
            if (ws == 3) begin
                if (e_tag != "R5") e_tag = "R1";
                take(m_skid);
                foreach (cur[i]) m_skid.push_back(cur[i]);
                if (m_skid.size() == 0) begin
                    e_rel = 1'b1;
                    m_state = 1;
                    e_tag = "R6";
                end else m_state = 3;
            end else begin
                rest = cur;
                take(rest);
                if (rest.size() > 0) begin
                    foreach (rest[i]) m_skid.push_back(rest[i]);
                    m_state = 2;
                    e_blk = !from_blk;
                end else begin
                    m_state = ws;
                    e_rel = from_blk;
                    if (from_blk) e_tag = "R6";
                end
            end
        end
    endtask

    // Compare registered outputs against the model's expectation.
    task automatic compare();
        check(int'(out_count) == e_out.size(), e_tag, "out_count", int'(out_count), e_out.size());
        for (int s = 0; s < DECODE_W; s++) begin
            if (s < e_out.size()) begin
                check(out_seq[s*SEQ_W +: SEQ_W] == e_out[s][TOK_W-1 -: SEQ_W], e_tag, "out_seq",
                      int'(out_seq[s*SEQ_W +: SEQ_W]), int'(e_out[s][TOK_W-1 -: SEQ_W]));
                check(out_issue_ready[s] == (e_out[s][SRC_W-1:0] == '0), "R10", "issue_ready",
                      int'(out_issue_ready[s]), int'(e_out[s][SRC_W-1:0] == '0));
            end
        end
        check(up_block == e_blk, e_tag, "up_block", int'(up_block), int'(e_blk));
        check(up_release == e_rel, e_tag, "up_release", int'(up_release), int'(e_rel));
        check(int'(stage_state) == m_state, e_tag, "stage_state", int'(stage_state), m_state);
        check(stage_active == (m_state == 3), "R5", "stage_active", int'(stage_active),
              int'(m_state == 3));
    endtask

    // Drive one cycle at the falling edge, advance the model, check after the next edge.
    task automatic drive_cycle(input int ntok, input bit [FETCH_W-1:0] kmask,
                               input bit [2:0] blk, input bit [2:0] rel,
                               input bit sq, input bit busy);
        tok_t cur[$];
        bit can_send;
        can_send = !held || inflight > 0;
        if (held && inflight > 0) inflight--;
        if (!can_send) ntok = 0;
        rel = rel & (m_flags | blk);
        in_seq  = '0;
        in_kill = '0;
        in_srcs = '0;
        for (int k = 0; k < ntok; k++) begin
            logic [SRC_W-1:0] ns = SRC_W'($urandom_range(0, 3));
            in_seq[k*SEQ_W +: SEQ_W] = SEQ_W'(seq_ctr);
            in_kill[k] = kmask[k];
            in_srcs[k*SRC_W +: SRC_W] = ns;
            cur.push_back({SEQ_W'(seq_ctr), kmask[k], ns});
            seq_ctr++;
        end
        in_count = IN_CW'(ntok);
        {cm_block, ex_block, rn_block}       = blk;
        {cm_release, ex_release, rn_release} = rel;
        cm_squash      = sq;
        cm_squash_busy = busy;
        model_step(cur, blk, rel, sq, busy);
        @(negedge clk);
        compare();
        sum_out += int'(out_count);
        if (up_block && !held) begin
            held = 1'b1;
            inflight = UP_LAT - 1;
        end
        if (up_release) held = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        int seed_val;
        int busy_left = 0;
        seed_val = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R11: reset state
        check(stage_state == 3'd0, "R11", "reset state", int'(stage_state), 0);
        check(out_count == '0, "R11", "reset out_count", int'(out_count), 0);
        check(!up_block && !up_release, "R11", "reset pulses",
              int'({up_block, up_release}), 0);
        rst_n = 1'b1;

        // R8/R10: four tokens, slot 1 killed -> two forwarded, one left, block
        drive_cycle(4, 4'b0010, 3'b000, 3'b000, 0, 0);
        check(int'(out_count) == 2, "R8", "forwarded with kill", int'(out_count), 2);
        check(up_block == 1'b1, "R8", "leftover block", int'(up_block), 1);
        repeat (3) drive_cycle(0, 4'b0, 3'b000, 3'b000, 0, 0);

        // R1: fill the skid to UP_LAT*FETCH_W, then drain all of it
        drive_cycle(4, 4'b0, 3'b001, 3'b000, 0, 0);
        drive_cycle(4, 4'b0, 3'b000, 3'b000, 0, 0);
        drive_cycle(4, 4'b0, 3'b000, 3'b000, 0, 0);
        sum_out = 0;
        drive_cycle(0, 4'b0, 3'b000, 3'b001, 0, 0);
        repeat (4) drive_cycle(0, 4'b0, 3'b000, 3'b000, 0, 0);
        check(sum_out == 2 * FETCH_W, "R1", "drained skid tokens", sum_out, 2 * FETCH_W);

        // R2: two stall sources, release one at a time
        drive_cycle(4, 4'b0, 3'b011, 3'b000, 0, 0);
        drive_cycle(0, 4'b0, 3'b000, 3'b001, 0, 0);
        check(int'(stage_state) == 2, "R2", "still blocked", int'(stage_state), 2);
        drive_cycle(0, 4'b0, 3'b000, 3'b010, 0, 0);
        repeat (3) drive_cycle(0, 4'b0, 3'b000, 3'b000, 0, 0);

        // R9/R3/R7: squash while blocked, then busy, then quiet
        drive_cycle(4, 4'b0, 3'b100, 3'b000, 0, 0);
        drive_cycle(4, 4'b0, 3'b000, 3'b100, 1, 0);
        check(up_release == 1'b1, "R9", "release on squash", int'(up_release), 1);
        drive_cycle(0, 4'b0, 3'b000, 3'b000, 0, 1);
        drive_cycle(3, 4'b0, 3'b000, 3'b000, 0, 0);
        check(int'(stage_state) != 4, "R7", "left squashing", int'(stage_state), 1);
        repeat (3) drive_cycle(0, 4'b0, 3'b000, 3'b000, 0, 0);

        // Random traffic
        for (int c = 0; c < 4000; c++) begin
            bit [2:0] blk = '0, rel = '0;
            bit [FETCH_W-1:0] km = '0;
            bit sq = 1'b0, busy = 1'b0;
            for (int k = 0; k < FETCH_W; k++) km[k] = ($urandom_range(0, 5) == 0);
            for (int s = 0; s < 3; s++) begin
                if (!m_flags[s]) blk[s] = ($urandom_range(0, 11) == 0);
                else             rel[s] = ($urandom_range(0, 3) == 0);
            end
            if (busy_left > 0) begin
                busy = 1'b1;
                busy_left--;
            end else if ($urandom_range(0, 39) == 0) begin
                sq = 1'b1;
                busy_left = $urandom_range(0, 2);
            end
            drive_cycle($urandom_range(0, FETCH_W), km, blk, rel, sq, busy);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule